// File: doc/BRIEF.md
# Byte DMA engine with window stop

This block moves single bytes between a local byte buffer and system memory. It drives a request/grant memory port and keeps a 64-bit working address that steps by one for each accepted byte. An operation is either drain (buffer to memory, a memory write) or fill (memory to buffer, a memory read). The local side, for example a flash sequencer, pushes bytes into the buffer or pops bytes from it through its own strobes.

An optional window stop pauses a transfer when the working address reaches the last byte of an aligned power-of-two window. The stop raises a DMA event, and software releases it by rewriting the low half of the address. The block also holds the interrupt status, status-enable and signal-enable registers. Status bits are cleared by writing ones. The status word carries two level flags that tell software whether a packet's worth of space or data is available in the buffer.

Top module: `bdma_window`

## Requirements
- R1: `mem_req` is high only while an operation is active, `dma_mode` equals 2, the engine is not stopped, and the buffer is not empty (drain) or not full (fill). Out of reset no request, no operation and an empty buffer are seen.
- R2: One byte moves in each cycle where `mem_req` and `mem_gnt` are both high. A drain drives `mem_we`=1 with the oldest buffer byte on `mem_wdata`. A fill drives `mem_we`=0 and stores `mem_rdata` in order. While a request waits for its grant, `mem_addr` holds.
- R3: Writing the low address word (`reg_sel`=0) or the high address word (`reg_sel`=1) reloads the working address from {high, low}. Each moved byte then adds one to it.
- R4: When `bnd_cfg[3]` is set and the moved byte's address has its low `bnd_cfg[2:0]`+12 bits all ones, that byte completes, the engine stops and a DMA event (status bit 6) is raised.
- R5: Only a write of the low address word releases a stop. A write of the high word does not.
- R6: An event sets its status bit only if the matching bit of the status-enable register (`reg_sel`=2) is set. The event bits are: bit 2 operation done, bit 6 DMA stop, and bits 3, 4 and 7 from `ext_evt`.
- R7: A write to the status register (`reg_sel`=4) clears every event bit whose data bit is one. Bit 5 always reads zero.
- R8: `irq_o` is high exactly when some status bit and the same bit of the signal-enable register (`reg_sel`=3) are both set.
- R9: Status bit 0 follows (buffer free space >= `pkt_size`). Status bit 1 follows (buffer occupancy >= `pkt_size` and `pkt_size` nonzero). Each is gated by its status-enable bit.
- R10: A drain operation ends when the buffer is empty, and a fill operation ends when the buffer is full. Either way `busy_o` falls and an operation-done event is raised.
- R11: An `op_start` pulse during an active operation is ignored, and the direction of the running operation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 low address, 1 high address, 2 status enable, 3 signal enable, 4 status clear |
| reg_wdata | input | 32 | Register write data |
| dma_mode | input | 2 | Transfer enable field; transfers run only at value 2 |
| bnd_cfg | input | 4 | Window stop: bit 3 enable, bits 2:0 size code |
| pkt_size | input | 11 | Packet size in bytes for the ready flags |
| op_start | input | 1 | Start pulse for an operation |
| op_to_mem | input | 1 | Direction of the started operation: 1 drain, 0 fill |
| ext_evt | input | 8 | Event pulses; only bits 3, 4 and 7 are used |
| loc_push | input | 1 | Local push into the buffer |
| loc_wdata | input | 8 | Local push data |
| loc_pop | input | 1 | Local pop from the buffer |
| loc_rdata | output | 8 | Oldest buffer byte |
| buf_level | output | 5 | Buffer occupancy |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Working system address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Memory grant; the byte moves in this cycle |
| mem_rdata | input | 8 | Memory read data, valid with the grant |
| busy_o | output | 1 | Operation active |
| status_o | output | 8 | Interrupt status |
| irq_o | output | 1 | Interrupt output |

## Verification
A granted byte changes the address, the buffer level and any stop at the clock edge that closes the grant cycle. Event bits are visible one edge after their cause, and the packet-ready flags are visible one edge after the level changes, so two edges after a push. A register write takes effect at the edge that samples it. The bench drives and samples 1 ns after the falling edge, so every value it reads has settled. It waits at least two edges before it reads a ready flag. It polls `busy_o` with a bounded loop before it checks the end state of an operation. The scoreboard monitor compares each memory write in the cycle whose grant it sees, with random grant stalls in between.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [2:0] {
      SEL_ADDR_LO = 3'd0,
      SEL_ADDR_HI = 3'd1,
      SEL_STAT_EN = 3'd2,
      SEL_SIG_EN  = 3'd3,
      SEL_STATUS  = 3'd4
   } reg_sel_e;

   localparam int ST_W      = 8;
   localparam int ST_WRDY   = 0;
   localparam int ST_RDRDY  = 1;
   localparam int ST_DONE   = 2;
   localparam int ST_ERR    = 4;
   localparam int ST_DMA    = 6;

   // bits that exist in the status word (bit 5 is reserved)
   localparam logic [ST_W-1:0] ST_IMPL = 8'hDF;
   // bits whose events come from outside the block
   localparam logic [ST_W-1:0] ST_EXT  = 8'h98;

   localparam logic [1:0] DMA_RUN = 2'd2;
endpackage

// File: rtl/bdma_fifo.sv
module bdma_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DW-1:0]                wdata,
   input  logic                         pop,
   output logic [DW-1:0]                rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bdma_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = store[rp];

   always_ff @(posedge clk) begin
      if (do_push) store[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + PW'(1);
         if (do_pop)  rp <= rp + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bdma_addr.sv
module bdma_addr #(
   parameter int AW      = 64,
   parameter int BSEL_W  = 3,
   parameter int BASE    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [31:0]       wdata,
   input  logic              step,
   input  logic              bnd_en,
   input  logic [BSEL_W-1:0] bnd_sel,
   output logic [AW-1:0]     addr,
   output logic              stopped,
   output logic              hit
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int HI_W = AW - 32;

   if (AW <= 32 || AW > 64) begin : g_bad_aw
      $error("bdma_addr: AW must lie in 33..64");
   end
   if (BASE + (1 << BSEL_W) - 1 > AW) begin : g_bad_window
      $error("bdma_addr: largest window exceeds the address width");
   end

   logic [HI_W-1:0] hi_q;
   logic [31:0]     lo_q;
   logic [AW-1:0]   mask;

   // run of ones, BASE + bnd_sel long
   assign mask = (AW'(1) << (BASE + int'(bnd_sel))) - AW'(1);
   assign hit  = step & bnd_en & ((addr & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_q    <= '0;
         addr    <= '0;
         stopped <= 1'b0;
      end else begin
         if (lo_we) begin
            lo_q <= wdata;
            addr <= {hi_q, wdata};
         end else if (hi_we) begin
            hi_q <= wdata[HI_W-1:0];
            addr <= {wdata[HI_W-1:0], lo_q};
         end else if (step) begin
            addr <= addr + AW'(1);
         end

         if (lo_we)    stopped <= 1'b0;
         else if (hit) stopped <= 1'b1;
      end
   end

   // R4
   stop_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !lo_we |=> stopped);
endmodule

// File: rtl/bdma_irq.sv
module bdma_irq
   import bdma_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_we,
   input  logic            sig_we,
   input  logic            clr_we,
   input  logic [ST_W-1:0] wdata,
   input  logic [ST_W-1:0] evt,
   input  logic            wr_ok,
   input  logic            rd_ok,
   output logic [ST_W-1:0] status,
   output logic            irq
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [ST_W-1:0] en_q, sig_q, lvl;

   assign lvl = ST_W'({rd_ok, wr_ok});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sig_q <= '0;
      end else begin
         if (en_we)  en_q  <= wdata & ST_IMPL;
         if (sig_we) sig_q <= wdata & ST_IMPL;
      end
   end

   for (genvar b = 0; b < ST_W; b++) begin : g_bit
      logic bit_q;
      if (b == ST_WRDY || b == ST_RDRDY) begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= en_q[b] & lvl[b];
         end
      end else if (ST_IMPL[b]) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  bit_q <= 1'b0;
            else if (evt[b] & en_q[b])   bit_q <= 1'b1;
            else if (clr_we & wdata[b])  bit_q <= 1'b0;
         end
      end else begin : g_rsvd
         assign bit_q = 1'b0;
      end
      assign status[b] = bit_q;
   end

   assign irq = |(status & sig_q);

   // R6
   done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_DONE]) |-> $past(en_q[ST_DONE]));

   // R7
   clear_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && wdata[ST_ERR] && !(evt[ST_ERR] && en_q[ST_ERR]) |=> !status[ST_ERR]);
endmodule

// File: rtl/bdma_window.sv
module bdma_window
   import bdma_pkg::*;
#(
   parameter int AW       = 64,
   parameter int DEPTH    = 16,
   parameter int PKT_W    = 11,
   parameter int BSEL_W   = 3,
   parameter int BND_BASE = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_we,
   input  logic [2:0]                  reg_sel,
   input  logic [31:0]                 reg_wdata,
   input  logic [1:0]                  dma_mode,
   input  logic [BSEL_W:0]             bnd_cfg,
   input  logic [PKT_W-1:0]            pkt_size,
   input  logic                        op_start,
   input  logic                        op_to_mem,
   input  logic [7:0]                  ext_evt,
   input  logic                        loc_push,
   input  logic [7:0]                  loc_wdata,
   input  logic                        loc_pop,
   output logic [7:0]                  loc_rdata,
   output logic [$clog2(DEPTH+1)-1:0]  buf_level,
   output logic                        mem_req,
   output logic                        mem_we,
   output logic [AW-1:0]               mem_addr,
   output logic [7:0]                  mem_wdata,
   input  logic                        mem_gnt,
   input  logic [7:0]                  mem_rdata,
   output logic                        busy_o,
   output logic [7:0]                  status_o,
   output logic                        irq_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = $clog2(DEPTH+1);

   if (PKT_W > 31) begin : g_bad_pkt
      $error("bdma_window: PKT_W too wide");
   end

   reg_sel_e       sel;
   logic           lo_we, hi_we;
   logic           busy_q, dir_q;
   logic           f_push, f_pop, f_empty, f_full;
   logic [7:0]     f_wdata, f_rdata;
   logic [CW-1:0]  f_count;
   logic           dma_stop, dma_hit, run, xfer;
   logic           own_push, own_pop, op_done;
   logic [ST_W-1:0] evt;
   logic [31:0]    free32, occ32, pkt32;

   assign sel   = reg_sel_e'(reg_sel);
   assign lo_we = reg_we && sel == SEL_ADDR_LO;
   assign hi_we = reg_we && sel == SEL_ADDR_HI;

   // buffer side ownership: the engine owns the side it moves bytes on
   assign own_push = busy_q & ~dir_q;
   assign own_pop  = busy_q &  dir_q;

   assign run     = busy_q && (dma_mode == DMA_RUN) && !dma_stop;
   assign mem_req = run & (dir_q ? ~f_empty : ~f_full);
   assign mem_we  = dir_q;
   assign mem_wdata = dir_q ? f_rdata : 8'h00;
   assign xfer    = mem_req & mem_gnt;

   assign f_push  = own_push ? xfer : loc_push;
   assign f_wdata = own_push ? mem_rdata : loc_wdata;
   assign f_pop   = own_pop ? xfer : loc_pop;
   assign loc_rdata = f_rdata;
   assign buf_level = f_count;

   bdma_fifo #(.DEPTH(DEPTH), .DW(8)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .wdata (f_wdata),
      .pop   (f_pop),
      .rdata (f_rdata),
      .count (f_count),
      .empty (f_empty),
      .full  (f_full)
   );

   bdma_addr #(.AW(AW), .BSEL_W(BSEL_W), .BASE(BND_BASE)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (lo_we),
      .hi_we   (hi_we),
      .wdata   (reg_wdata),
      .step    (xfer),
      .bnd_en  (bnd_cfg[BSEL_W]),
      .bnd_sel (bnd_cfg[BSEL_W-1:0]),
      .addr    (mem_addr),
      .stopped (dma_stop),
      .hit     (dma_hit)
   );

   // operation control
   assign op_done = busy_q & (dir_q ? f_empty : f_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= 1'b1;
      end else if (op_done) begin
         busy_q <= 1'b0;
      end else if (op_start && !busy_q) begin
         busy_q <= 1'b1;
         dir_q  <= op_to_mem;
      end
   end
   assign busy_o = busy_q;

   // packet-ready levels
   assign free32 = 32'(CW'(DEPTH) - f_count);
   assign occ32  = 32'(f_count);
   assign pkt32  = 32'(pkt_size);

   assign evt = (ext_evt & ST_EXT) | {1'b0, dma_hit, 3'b000, op_done, 2'b00};

   bdma_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (reg_we && sel == SEL_STAT_EN),
      .sig_we (reg_we && sel == SEL_SIG_EN),
      .clr_we (reg_we && sel == SEL_STATUS),
      .wdata  (reg_wdata[ST_W-1:0]),
      .evt    (evt),
      .wr_ok  (free32 >= pkt32),
      .rd_ok  ((occ32 >= pkt32) && (pkt32 != 32'd0)),
      .status (status_o),
      .irq    (irq_o)
   );

   // R1
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (dma_mode == DMA_RUN) && busy_q);

   // R5
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stop |-> !mem_req);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && !reg_we |=> $stable(mem_addr));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer && !reg_we |=> mem_addr == $past(mem_addr) + AW'(1));
endmodule

// File: tb/bdma_window_bench.sv
module bdma_window_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  dma_mode = 2'd0;
   logic [3:0]  bnd_cfg = '0;
   logic [10:0] pkt_size = '0;
   logic        op_start = 1'b0;
   logic        op_to_mem = 1'b1;
   logic [7:0]  ext_evt = '0;
   logic        loc_push = 1'b0;
   logic [7:0]  loc_wdata = '0;
   logic        loc_pop = 1'b0;
   logic [7:0]  loc_rdata;
   logic [4:0]  buf_level;
   logic        mem_req, mem_we, mem_gnt;
   logic [63:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        busy_o, irq_o;
   logic [7:0]  status_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0]  lfsr = 8'h5B;
   logic        stall_en = 1'b1;
   logic [63:0] exp_addr_q[$];
   logic [7:0]  exp_data_q[$];

   bdma_window u_bdma_window (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .dma_mode(dma_mode), .bnd_cfg(bnd_cfg),
      .pkt_size(pkt_size), .op_start(op_start), .op_to_mem(op_to_mem),
      .ext_evt(ext_evt), .loc_push(loc_push), .loc_wdata(loc_wdata),
      .loc_pop(loc_pop), .loc_rdata(loc_rdata), .buf_level(buf_level),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .busy_o(busy_o), .status_o(status_o), .irq_o(irq_o)
   );

   always #2.5 clk = ~clk;

   // memory model: stalls from an LFSR, read data derived from the address
   assign mem_gnt   = mem_req & (lfsr[0] | ~stall_en);
   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares every memory write against the queue
   always @(negedge clk) begin
      logic [63:0] a;
      logic [7:0]  d;
      #2;
      if (rst_n && mem_req && mem_gnt && mem_we) begin
         if (exp_addr_q.size() == 0) begin
            check("R2 unexpected write", mem_addr, 64'hFFFF_FFFF_FFFF_FFFF);
         end else begin
            a = exp_addr_q.pop_front();
            d = exp_data_q.pop_front();
            check("R2 write address", mem_addr, a);
            check("R2 write data", 64'(mem_wdata), 64'(d));
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(logic [2:0] s, logic [31:0] d);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      step(1);
      reg_we = 1'b0;
   endtask

   task automatic push_local(logic [7:0] d);
      loc_push = 1'b1; loc_wdata = d;
      step(1);
      loc_push = 1'b0;
   endtask

   task automatic start_op(logic to_mem);
      op_start = 1'b1; op_to_mem = to_mem;
      step(1);
      op_start = 1'b0;
   endtask

   task automatic expect_wr(logic [63:0] a, logic [7:0] d);
      exp_addr_q.push_back(a);
      exp_data_q.push_back(d);
   endtask

   task automatic wait_idle(string req);
      int n = 0;
      while (busy_o && n < 3000) begin
         step(1);
         n++;
      end
      check(req, 64'(busy_o), 64'd0);
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state (R1)
      check("R1 reset status", 64'(status_o), 64'd0);
      check("R1 reset req", 64'(mem_req), 64'd0);
      check("R1 reset busy", 64'(busy_o), 64'd0);
      check("R1 reset level", 64'(buf_level), 64'd0);
      check("R8 reset irq", 64'(irq_o), 64'd0);

      // R9 ready flags
      wr(3'd2, 32'h03);
      pkt_size = 11'd4;
      step(2);
      check("R9 empty flags", 64'(status_o[1:0]), 64'b01);
      for (int i = 0; i < 4; i++) push_local(8'(8'h40 + i));
      step(2);
      check("R9 four bytes", 64'(status_o[1:0]), 64'b11);
      pkt_size = 11'd0;
      step(2);
      check("R9 zero packet", 64'(status_o[1:0]), 64'b01);
      pkt_size = 11'd13;
      step(2);
      check("R9 free below packet", 64'(status_o[1:0]), 64'b00);
      pkt_size = 11'd12;
      step(2);
      check("R9 free equals packet", 64'(status_o[1:0]), 64'b01);
      check("R2 local head", 64'(loc_rdata), 64'h40);
      loc_pop = 1'b1;
      step(4);
      loc_pop = 1'b0;
      check("R2 local drain", 64'(buf_level), 64'd0);

      // R6 gating and R7 reserved bit
      ext_evt = 8'h08;
      step(1);
      ext_evt = 8'h00;
      step(1);
      check("R6 disabled event", 64'(status_o[3]), 64'd0);
      wr(3'd2, 32'hFF);
      ext_evt = 8'hB8;
      step(1);
      ext_evt = 8'h00;
      step(1);
      check("R6 enabled events", 64'(status_o & 8'hB8), 64'h98);
      check("R7 reserved bit", 64'(status_o[5]), 64'd0);

      // R8 irq and R7 clear
      step(1);
      check("R8 no signal enable", 64'(irq_o), 64'd0);
      wr(3'd3, 32'h10);
      check("R8 irq raised", 64'(irq_o), 64'd1);
      wr(3'd4, 32'h10);
      check("R7 bit4 cleared", 64'(status_o[4]), 64'd0);
      check("R7 others kept", 64'(status_o & 8'h88), 64'h88);
      check("R8 irq dropped", 64'(irq_o), 64'd0);
      wr(3'd4, 32'hFF);
      wr(3'd3, 32'h40);

      // R1 mode gate, R3 reload, R10 drain completion
      for (int i = 0; i < 6; i++) push_local(8'(8'h10 + i));
      wr(3'd1, 32'h1);
      wr(3'd0, 32'h2000);
      dma_mode = 2'd1;
      start_op(1'b1);
      step(5);
      check("R1 mode not 2", 64'(mem_req), 64'd0);
      check("R3 reload", mem_addr, 64'h1_0000_2000);
      check("R1 no move", 64'(buf_level), 64'd6);
      for (int i = 0; i < 6; i++) expect_wr(64'h1_0000_2000 + 64'(i), 8'(8'h10 + i));
      dma_mode = 2'd2;
      wait_idle("R10 drain ends");
      step(1);
      check("R2 all written", 64'(exp_addr_q.size()), 64'd0);
      check("R3 stepped", mem_addr, 64'h1_0000_2006);
      check("R10 done event", 64'(status_o[2]), 64'd1);

      // R4 window stop at 4 KiB, R5 release, R11 ignored start
      wr(3'd4, 32'hFF);
      wr(3'd1, 32'h0);
      bnd_cfg = 4'b1000;
      for (int i = 0; i < 8; i++) push_local(8'(8'h80 + i));
      wr(3'd0, 32'h5FFD);
      for (int i = 0; i < 3; i++) expect_wr(64'h5FFD + 64'(i), 8'(8'h80 + i));
      start_op(1'b1);
      step(40);
      check("R4 bytes before stop", 64'(exp_addr_q.size()), 64'd0);
      check("R4 level at stop", 64'(buf_level), 64'd5);
      check("R4 address past window", mem_addr, 64'h6000);
      check("R4 no request", 64'(mem_req), 64'd0);
      check("R4 dma event", 64'(status_o[6]), 64'd1);
      check("R8 dma irq", 64'(irq_o), 64'd1);
      wr(3'd1, 32'h0);
      step(10);
      check("R5 high write keeps stop", 64'(buf_level), 64'd5);
      start_op(1'b0);
      for (int i = 0; i < 5; i++) expect_wr(64'h6000 + 64'(i), 8'(8'h83 + i));
      wr(3'd0, 32'h6000);
      wait_idle("R5 resumed drain ends");
      step(1);
      check("R11 direction kept", 64'(exp_addr_q.size()), 64'd0);
      check("R5 final address", mem_addr, 64'h6005);

      // R4 wider window: 8 KiB
      wr(3'd4, 32'hFF);
      bnd_cfg = 4'b1001;
      for (int i = 0; i < 6; i++) push_local(8'(8'hC0 + i));
      wr(3'd0, 32'h6FFE);
      for (int i = 0; i < 6; i++) expect_wr(64'h6FFE + 64'(i), 8'(8'hC0 + i));
      start_op(1'b1);
      wait_idle("R4 no stop inside window");
      step(1);
      check("R4 no event mid window", 64'(status_o[6]), 64'd0);
      check("R4 crossed 4K", mem_addr, 64'h7004);
      for (int i = 0; i < 4; i++) push_local(8'(8'hD0 + i));
      wr(3'd0, 32'h7FFE);
      for (int i = 0; i < 2; i++) expect_wr(64'h7FFE + 64'(i), 8'(8'hD0 + i));
      start_op(1'b1);
      step(40);
      check("R4 stop at 8K end", 64'(buf_level), 64'd2);
      check("R4 event 8K", 64'(status_o[6]), 64'd1);
      for (int i = 0; i < 2; i++) expect_wr(64'h8000 + 64'(i), 8'(8'hD2 + i));
      wr(3'd0, 32'h8000);
      wait_idle("R5 release 8K");

      // R2/R10 fill direction
      wr(3'd4, 32'hFF);
      bnd_cfg = 4'b0000;
      wr(3'd1, 32'h2);
      wr(3'd0, 32'h100);
      start_op(1'b0);
      wait_idle("R10 fill ends");
      step(1);
      check("R10 buffer full", 64'(buf_level), 64'd16);
      check("R10 fill done event", 64'(status_o[2]), 64'd1);
      check("R3 fill address", mem_addr, 64'h2_0000_0110);
      for (int i = 0; i < 16; i++) begin
         check("R2 fill data", 64'(loc_rdata), 64'(8'(i) ^ 8'hA5));
         loc_pop = 1'b1;
         step(1);
         loc_pop = 1'b0;
      end
      check("R2 fill drained", 64'(buf_level), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule